// File: doc/BRIEF.md
# Multi-mode color palette register file

This block holds the color palette registers of a graphics controller as seen by the CPU. The CPU sees four byte ports: an index port and three color ports for green, red and blue. What those ports reach depends on two mode inputs. With neither mode set, the ports reach four packed digital palette bytes. With the 16-color mode set, the three color ports reach a 16-entry table of 4-bit components. With the 256-color mode set, they reach a 256-entry table of byte components. In both analog modes the index port selects the entry.

After reset the block fills its tables itself, one entry per clock. The 256-entry table gets a generated gray and primary-color ramp. The 16-entry table gets a standard set of colors when `analog_en_i` is high, and stays all zero when it is low. While the fill runs, `busy_o` is high, `ready_o` is low, and CPU writes are dropped. Some writes change the displayed colors; each of these raises `redraw_o` for one cycle, so that the display path can rebuild its cached colors.

Top module: `pal_regfile`

## Requirements
- R1: After reset, with both mode inputs low, reads give these values: port 0 (index) 0x37, port 1 (green) 0x15, port 2 (red) 0x26, port 3 (blue) 0x04. Port 0 reaches digital byte 3, port 1 byte 1, port 2 byte 2 and port 3 byte 0.
- R2: After reset is released, `busy_o` is high and `ready_o` is low for exactly 256 clocks. After that, `busy_o` stays low until the next reset. A write presented while `busy_o` is high changes no register and gives no redraw pulse.
- R3: At the end of the fill, each 256-table entry e holds a value set by its group base b = e with the low 3 bits cleared and by j = e mod 8.
  - When j = 0, all three components hold 0 if b = 0, and b−4 otherwise.
  - When j ≠ 0, green holds b+7 if j bit 2 is set, red holds b+7 if j bit 1 is set, and blue holds b+7 if j bit 0 is set. Each component whose bit is clear holds 0.
- R4: If `analog_en_i` is high during the fill, 16-table entry e gets these components:
  - for e < 8, each component is 7 or 0, according to bits 2, 1 and 0 of e (green, red, blue);
  - entry 8 has all components 4;
  - for e from 9 to 15, each component is 15 or 0, by the same bits.
  If `analog_en_i` is low, every entry is 0.
- R5: When either analog mode is active, a write to port 0 stores all 8 bits of the index, and a read of port 0 returns it.
- R6: In 16-color mode, ports 1 to 3 reach green, red and blue of entry index[3:0]. A write keeps only data bits 3:0, and a read returns those bits with bits 7:4 zero.
- R7: When `mode256_i` is high, ports 1 to 3 reach green, red and blue of the 256-table entry named by the full index. This holds whether or not `mode16_i` is also high.
- R8: In digital mode, a write to a port updates the digital byte that the port reads back, as mapped in R1.
- R9: A digital-mode write raises `redraw_o` only if it changes a bit of the target byte under mask 0x77.
- R10: Every color-port write in an analog mode raises `redraw_o`. The pulse lasts one cycle and comes in the cycle after the write. Writes to port 0 in an analog mode give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode16_i | input | 1 | 16-color analog mode |
| mode256_i | input | 1 | 256-color analog mode (has priority) |
| analog_en_i | input | 1 | Fill the 16-entry table with defaults during reset fill |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 2 | Port select: 0 index, 1 green, 2 red, 3 blue |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected port (combinational) |
| ready_o | output | 1 | Writes accepted |
| busy_o | output | 1 | Reset fill in progress |
| redraw_o | output | 1 | One-cycle redraw request |

## Verification
The bench targets the permuted digital read mapping: a design that got it wrong would return the right bytes on the wrong ports. It also targets the 0x77 change mask, using writes that flip only bits 7 or 3. Such writes would give a wrong redraw pulse if the mask were missing. For the fill, the bench sweeps all 256 table entries and compares each against its generated value, which exposes an off-by-one group base or a wrong j = 0 case. It also writes during the fill, which catches a design that lets those writes through. Finally, it sets both mode inputs together and indexes past 15: a design with the wrong priority would land in the 16-entry table or keep the high nibble of 16-color data.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {PORT_IDX = 2'd0, PORT_G = 2'd1, PORT_R = 2'd2, PORT_B = 2'd3} port_e;

  typedef struct packed { logic [7:0] g; logic [7:0] r; logic [7:0] b; } rgb8_t;
  typedef struct packed { logic [3:0] g; logic [3:0] r; logic [3:0] b; } rgb4_t;

  // digital byte reached by each port
  function automatic logic [1:0] dig_slot(logic [1:0] p);
    case (p)
      2'd0:    return 2'd3;
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic rgb4_t narrow_default(logic [3:0] e);
    logic [3:0] lvl;
    rgb4_t v;
    lvl = e[3] ? 4'hf : 4'h7;
    v.g = e[2] ? lvl : 4'h0;
    v.r = e[1] ? lvl : 4'h0;
    v.b = e[0] ? lvl : 4'h0;
    if (e == 4'd8) v = '{g: 4'h4, r: 4'h4, b: 4'h4};
    return v;
  endfunction

  function automatic rgb8_t wide_default(logic [7:0] e);
    logic [7:0] base, lvl;
    rgb8_t v;
    base = {e[7:3], 3'b000};
    if (e[2:0] == 3'd0) begin
      lvl = (base == 8'd0) ? 8'd0 : base - 8'd4;
      v = '{g: lvl, r: lvl, b: lvl};
    end else begin
      lvl = base + 8'd7;
      v.g = e[2] ? lvl : 8'd0;
      v.r = e[1] ? lvl : 8'd0;
      v.b = e[0] ? lvl : 8'd0;
    end
    return v;
  endfunction

  function automatic logic [7:0] pick8(rgb8_t v, logic [1:0] p);
    case (p)
      2'd1:    return v.g;
      2'd2:    return v.r;
      2'd3:    return v.b;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [3:0] pick4(rgb4_t v, logic [1:0] p);
    case (p)
      2'd1:    return v.g;
      2'd2:    return v.r;
      2'd3:    return v.b;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/pal_fill_seq.sv
module pal_fill_seq #(
  parameter int N = 256,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          busy_o,
  output logic [AW-1:0] ent_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b1;
      ent_o  <= '0;
    end else if (busy_o) begin
      ent_o <= ent_o + 1'b1;
      if (ent_o == AW'(N - 1)) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pal_digital.sv
module pal_digital #(
  parameter logic [7:0] CHG_MASK = 8'h77
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [1:0]      slot_i,
  input  logic [7:0]      wdata_i,
  output logic [3:0][7:0] bytes_o,
  output logic            chg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bytes_o <= 32'h3726_1504;
    else if (we_i) bytes_o[slot_i] <= wdata_i;
  end

  assign chg_o = |((bytes_o[slot_i] ^ wdata_i) & CHG_MASK);
endmodule

// File: rtl/pal_analog.sv
module pal_analog
  import pal_pkg::*;
#(
  parameter int WIDE_N   = 256,
  parameter int NARROW_N = 16,
  localparam int WAW = $clog2(WIDE_N),
  localparam int NAW = $clog2(NARROW_N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           fill_i,
  input  logic           fill_narrow_i,
  input  logic [WAW-1:0] fill_ent_i,
  input  logic           wide_we_i,
  input  logic           narrow_we_i,
  input  logic [1:0]     comp_i,
  input  logic [WAW-1:0] ent_i,
  input  logic [7:0]     wdata_i,
  output rgb8_t          wide_o,
  output rgb4_t          narrow_o
);
  rgb8_t wide_q   [WIDE_N];
  rgb4_t narrow_q [NARROW_N];

  always_ff @(posedge clk_i) begin
    if (fill_i) wide_q[fill_ent_i] <= wide_default(8'(fill_ent_i));
    else if (wide_we_i) begin
      case (comp_i)
        PORT_G:  wide_q[ent_i].g <= wdata_i;
        PORT_R:  wide_q[ent_i].r <= wdata_i;
        PORT_B:  wide_q[ent_i].b <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NARROW_N; k++) narrow_q[k] <= '0;
    end else if (fill_i) begin
      if (fill_narrow_i && fill_ent_i < WAW'(NARROW_N))
        narrow_q[fill_ent_i[NAW-1:0]] <= narrow_default(4'(fill_ent_i));
    end else if (narrow_we_i) begin
      case (comp_i)
        PORT_G:  narrow_q[ent_i[NAW-1:0]].g <= wdata_i[3:0];
        PORT_R:  narrow_q[ent_i[NAW-1:0]].r <= wdata_i[3:0];
        PORT_B:  narrow_q[ent_i[NAW-1:0]].b <= wdata_i[3:0];
        default: ;
      endcase
    end
  end

  assign wide_o   = wide_q[ent_i];
  assign narrow_o = narrow_q[ent_i[NAW-1:0]];
endmodule

// File: rtl/pal_regfile.sv
module pal_regfile
  import pal_pkg::*;
#(
  parameter int WIDE_N   = 256,
  parameter int NARROW_N = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode16_i,
  input  logic       mode256_i,
  input  logic       analog_en_i,
  input  logic       wr_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       ready_o,
  output logic       busy_o,
  output logic       redraw_o
);
  localparam int WAW = $clog2(WIDE_N);

  logic            busy, wr_ok, analog, data_port;
  logic            dig_we, dig_chg, wide_we, narrow_we;
  logic [WAW-1:0]  fill_ent;
  logic [7:0]      idx_q;
  logic [3:0][7:0] dig_bytes;
  rgb8_t           wide_rd;
  rgb4_t           narrow_rd;

  pal_fill_seq #(.N(WIDE_N)) u_fill (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy), .ent_o(fill_ent)
  );

  assign wr_ok     = wr_i & ~busy;
  assign analog    = mode16_i | mode256_i;
  assign data_port = (addr_i != 2'd0);
  assign dig_we    = wr_ok & ~analog;
  assign wide_we   = wr_ok & mode256_i & data_port;
  assign narrow_we = wr_ok & mode16_i & ~mode256_i & data_port;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (wr_ok && analog && !data_port) idx_q <= wdata_i;
  end

  pal_digital u_dig (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(dig_we), .slot_i(dig_slot(addr_i)),
    .wdata_i(wdata_i), .bytes_o(dig_bytes), .chg_o(dig_chg)
  );

  pal_analog #(.WIDE_N(WIDE_N), .NARROW_N(NARROW_N)) u_ana (
    .clk_i(clk_i), .rst_ni(rst_ni), .fill_i(busy), .fill_narrow_i(analog_en_i),
    .fill_ent_i(fill_ent), .wide_we_i(wide_we), .narrow_we_i(narrow_we),
    .comp_i(addr_i), .ent_i(WAW'(idx_q)), .wdata_i(wdata_i),
    .wide_o(wide_rd), .narrow_o(narrow_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) redraw_o <= 1'b0;
    else         redraw_o <= wide_we | narrow_we | (dig_we & dig_chg);
  end

  always_comb begin
    if (analog && !data_port) rdata_o = idx_q;
    else if (mode256_i)       rdata_o = pick8(wide_rd, addr_i);
    else if (mode16_i)        rdata_o = {4'h0, pick4(narrow_rd, addr_i)};
    else                      rdata_o = dig_bytes[dig_slot(addr_i)];
  end

  assign busy_o  = busy;
  assign ready_o = ~busy;
endmodule

// File: rtl/pal_regfile_chk.sv
module pal_regfile_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode16_i,
  input logic       mode256_i,
  input logic       wr_i,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       ready_o,
  input logic       busy_o,
  input logic       redraw_o,
  input logic [7:0] idx_q
);
  // R10
  redraw_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redraw_o |-> $past(wr_i && ready_o));
  // R10
  ana_redraw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ready_o && addr_i != 2'd0 && (mode16_i || mode256_i)) |=> redraw_o);
  // R2
  busy_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !busy_o);
  // R2
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !redraw_o);
  // R5
  idx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ready_o && addr_i == 2'd0 && (mode16_i || mode256_i)) |=> idx_q == $past(wdata_i));
  // R6
  narrow_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode16_i && !mode256_i && addr_i != 2'd0) |-> rdata_o[7:4] == 4'h0);
endmodule

bind pal_regfile pal_regfile_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode16_i(mode16_i), .mode256_i(mode256_i),
  .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .ready_o(ready_o), .busy_o(busy_o), .redraw_o(redraw_o), .idx_q(idx_q)
);

// File: tb/tb_pal_regfile.sv
`timescale 1ns/1ps
module tb_pal_regfile;
  logic clk = 0, rst_ni = 0;
  logic mode16 = 0, mode256 = 0, analog_en = 1, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic ready, busy, redraw;

  pal_regfile dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode16_i(mode16), .mode256_i(mode256),
    .analog_en_i(analog_en), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ready_o(ready), .busy_o(busy), .redraw_o(redraw)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference model
  int m_dig [4];
  int m_n16 [16][3];
  int m_w   [256][3];
  int m_idx, m_cnt;
  bit m_busy, m_rd;

  function automatic int n16_def(int e, int c);
    int bitv = (e >> (2 - c)) & 1;
    if (e == 8) return 4;
    return (e < 8) ? 7 * bitv : 15 * bitv;
  endfunction

  function automatic int w_def(int e, int c);
    int b = (e / 8) * 8, j = e % 8;
    if (j == 0) return (b == 0) ? 0 : b - 4;
    return ((j >> (2 - c)) & 1) * (b + 7);
  endfunction

  function automatic int dig_of(int p);
    return (p == 0) ? 3 : (p == 3) ? 0 : p;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_dig[0] = 'h04; m_dig[1] = 'h15; m_dig[2] = 'h26; m_dig[3] = 'h37;
      for (int e = 0; e < 16; e++) for (int c = 0; c < 3; c++) m_n16[e][c] = 0;
      m_idx = 0; m_cnt = 0; m_busy = 1; m_rd = 0;
    end else begin
      m_rd = 0;
      if (m_busy) begin
        for (int c = 0; c < 3; c++) begin
          m_w[m_cnt][c] = w_def(m_cnt, c);
          if (analog_en && m_cnt < 16) m_n16[m_cnt][c] = n16_def(m_cnt, c);
        end
        m_cnt++;
        if (m_cnt == 256) m_busy = 0;
      end else if (wr) begin
        if (mode16 || mode256) begin
          if (addr == 0) m_idx = wdata;
          else begin
            m_rd = 1;
            if (mode256) m_w[m_idx][addr-1] = wdata;
            else m_n16[m_idx % 16][addr-1] = wdata & 'hf;
          end
        end else begin
          if (((m_dig[dig_of(addr)] ^ wdata) & 'h77) != 0) m_rd = 1;
          m_dig[dig_of(addr)] = wdata;
        end
      end
    end
  end

  function automatic int exp_rd();
    if ((mode16 || mode256) && addr == 0) return m_idx;
    if (mode256) return m_w[m_idx][addr-1];
    if (mode16) return m_n16[m_idx % 16][addr-1];
    return m_dig[dig_of(addr)];
  endfunction

  task automatic chk(string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("busy", busy, m_busy);
      chk("ready", ready, !m_busy);
      chk("redraw", redraw, m_rd);
      chk("rdata", rdata, exp_rd());
    end
  end

  task automatic do_reset(bit aen);
    @(posedge clk); #1 rst_ni = 0; analog_en = aen; mode16 = 0; mode256 = 0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1;
  endtask

  task automatic wr_port(int a, int d);
    @(posedge clk); #1 wr = 1; addr = 2'(a); wdata = 8'(d);
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic rd_port(int a);
    @(posedge clk); #1 addr = 2'(a);
  endtask

  initial begin
    // R2: fill with writes attempted while busy
    cur_req = "R2";
    do_reset(1);
    repeat (5) @(posedge clk);
    #1 wr = 1; addr = 1; wdata = 8'hff;
    repeat (4) @(posedge clk);
    #1 wr = 0;
    repeat (255) @(posedge clk);
    // R1: digital reset values and permuted mapping
    cur_req = "R1";
    for (int a = 0; a < 4; a++) rd_port(a);
    // R9: change mask on digital bytes
    cur_req = "R9";
    wr_port(0, 'hb7);
    wr_port(0, 'h30);
    wr_port(3, 'h0c);
    wr_port(2, 'h26);
    wr_port(2, 'h27);
    // R8: digital write/readback per port
    cur_req = "R8";
    wr_port(1, 'h5a);
    for (int a = 0; a < 4; a++) rd_port(a);
    // R5: index register
    cur_req = "R5";
    #1 mode16 = 1;
    wr_port(0, 'h25);
    rd_port(0);
    // R4: 16-entry defaults
    cur_req = "R4";
    for (int e = 0; e < 16; e++) begin
      wr_port(0, e + 16 * (e % 3));
      for (int a = 1; a < 4; a++) rd_port(a);
    end
    // R6: nibble truncation and low-4 entry select
    cur_req = "R6";
    wr_port(0, 'h3a);
    wr_port(2, 'hab);
    wr_port(1, 'hf1);
    for (int a = 0; a < 4; a++) rd_port(a);
    // R10: analog writes always pulse, index writes do not
    cur_req = "R10";
    wr_port(3, 'h00);
    wr_port(3, 'h00);
    wr_port(0, 'h07);
    // R3: full sweep of 256-entry fill with both modes set
    cur_req = "R3";
    #1 mode256 = 1;
    for (int e = 0; e < 256; e++) begin
      wr_port(0, e);
      for (int a = 1; a < 4; a++) rd_port(a);
    end
    // R7: priority and full-index addressing
    cur_req = "R7";
    wr_port(0, 'h9b);
    wr_port(3, 'hc5);
    wr_port(1, 'h3c);
    for (int a = 0; a < 4; a++) rd_port(a);
    #1 mode16 = 0;
    for (int a = 0; a < 4; a++) rd_port(a);
    #1 mode16 = 1; mode256 = 0;
    for (int a = 0; a < 4; a++) rd_port(a);
    // R4: analog disabled leaves 16-entry table zero
    cur_req = "R4";
    do_reset(0);
    repeat (258) @(posedge clk);
    #1 mode16 = 1;
    for (int e = 0; e < 16; e++) begin
      wr_port(0, e);
      for (int a = 1; a < 4; a++) rd_port(a);
    end
    @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule